// File: doc/BRIEF.md
# Interrupt Event Pacer

The pacer sits between a raw per-channel completion event and the interrupt line that serves it. It merges bursts of completion pulses so that the host takes one interrupt for a group of events rather than one per packet. Two limits apply at the same time. One is an event count, tracked by a divide machine. The other is an elapsed time measured in prescaler ticks, tracked by a timed-delay machine. Whichever limit is reached first produces a single output pulse, and both machines then start over.

All pins are plain control and status signals. No data is carried, so there is no valid/ready handshake and no back-pressure: an input pulse is accepted in the cycle it is high. One 32-bit configuration word sets the behaviour. The current event count and the elapsed time are brought out as status.

Top module: `event_pacer`

## Requirements
- R1: While reset is active and in the first cycle after it, `evt_out` is 0, `cnt_o` is 0 and `time_o` is 0.
- R2: The time limit is taken from `cfg_word[27:16]` and the count limit from `cfg_word[15:8]`. Bit 0 enables the divide path and bit 1 enables the delay path.
- R3: With the divide path enabled and a count limit L > 0, the first accepted event sets the count to 1 and each later event adds 1. The event that brings the count to L raises `evt_out` in the next cycle.
- R4: With the delay path enabled and a time limit T > 0, an event seen while the delay machine is idle starts a delay with the elapsed time at 0. The elapsed time advances only in cycles where `tick` is 1. The tick that brings it to T raises `evt_out` in the next cycle.
- R5: A time limit of 0 disables the delay path, so only the count criterion can produce an output.
- R6: A count limit of 0 passes every input pulse straight through to `evt_out` one cycle later, whatever the enable bits are.
- R7: When either limit fires, exactly one output pulse results, even if both limits are met in the same cycle. In that output cycle `cnt_o` and `time_o` both read 0.
- R8: Events arriving during a running delay leave the elapsed time untouched. An event arriving in the output cycle starts a new batch.
- R9: `cfg_word` bits 3:2, 7:4 and 31:28 have no effect on the output or the status.
- R10: With both enable bits at 0 and a nonzero count limit, events are ignored: `evt_out` stays 0 and `cnt_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Raw completion event, one pulse per event |
| tick | input | 1 | Prescaler tick that advances the elapsed time |
| cfg_word | input | 32 | Time limit, count limit and enable bits |
| evt_out | output | 1 | Paced event pulse |
| cnt_o | output | 8 | Current event count |
| time_o | output | 12 | Current elapsed time in ticks |

## Verification
Every result is registered once. An event or tick sampled at a clock edge shows its effect on `evt_out`, `cnt_o` and `time_o` from that same edge onward. This includes the pass-through case, which is therefore one cycle late. The bench drives inputs on the falling edge. At each rising edge its behavioural model steps once using the inputs it has just sampled. One time unit after the edge, it compares all three outputs with the model. The run is split into segments, each under its own reset and configuration word. Each segment aims at one requirement, and a failing comparison names that requirement.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int unsigned TIME_W = 12;
  localparam int unsigned CNT_W  = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIRE = 2'd2
  } pace_ph_e;

  typedef struct packed {
    logic [TIME_W-1:0] time_lim;
    logic [CNT_W-1:0]  cnt_lim;
    logic              div_en;
    logic              dly_en;
  } pace_cfg_t;
endpackage

// File: rtl/pace_cfg_decode.sv
module pace_cfg_decode
  import pacer_pkg::*;
#(
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned TIME_LSB = 16,
  parameter int unsigned CNT_LSB  = 8,
  parameter int unsigned DIV_BIT  = 0,
  parameter int unsigned DLY_BIT  = 1
) (
  input  logic [CFG_W-1:0] cfg_word,
  output pace_cfg_t        cfg
);
  // Only the listed fields are decoded; every other bit is ignored.
  logic unused_bits;
  assign unused_bits = ^cfg_word;

  always_comb begin
    cfg.time_lim = cfg_word[TIME_LSB +: TIME_W];
    cfg.cnt_lim  = cfg_word[CNT_LSB +: CNT_W];
    cfg.div_en   = cfg_word[DIV_BIT];
    cfg.dly_en   = cfg_word[DLY_BIT];
  end
endmodule

// File: rtl/pace_divider.sv
module pace_divider
  import pacer_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         en,
  input  logic [W-1:0] lim,
  input  logic         flush,
  output logic [W-1:0] cnt,
  output logic         fire,
  output logic         at_out
);
  pace_ph_e ph;
  logic [W:0] cnt_next;

  assign cnt_next = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  assign fire     = evt && en && (cnt_next >= {1'b0, lim});
  assign at_out   = (ph == PH_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (flush) begin
      ph  <= PH_FIRE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_RUN: if (evt && en) cnt <= cnt_next[W-1:0];
        default: begin
          if (evt && en) begin
            ph  <= PH_RUN;
            cnt <= {{(W-1){1'b0}}, 1'b1};
          end else begin
            ph  <= PH_IDLE;
          end
        end
      endcase
    end
  end

  // R3: with a steady nonzero limit the count never reaches it
  p_cnt_below_lim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lim != '0 && $stable(lim)) |-> (cnt < lim));
endmodule

// File: rtl/pace_delay.sv
module pace_delay
  import pacer_pkg::*;
#(
  parameter int unsigned W = TIME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         tick,
  input  logic         en,
  input  logic [W-1:0] lim,
  input  logic         flush,
  output logic [W-1:0] tim,
  output logic         fire,
  output logic         at_out
);
  pace_ph_e ph;
  logic [W:0] tim_next;

  assign tim_next = {1'b0, tim} + {{W{1'b0}}, 1'b1};
  assign fire     = en && (ph == PH_RUN) && tick && (tim_next >= {1'b0, lim});
  assign at_out   = (ph == PH_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      tim <= '0;
    end else if (flush) begin
      ph  <= PH_FIRE;
      tim <= '0;
    end else begin
      unique case (ph)
        PH_RUN: if (tick) tim <= tim_next[W-1:0];
        default: begin
          tim <= '0;
          if (evt && en) ph <= PH_RUN;
          else           ph <= PH_IDLE;
        end
      endcase
    end
  end

  // R4: elapsed time holds in cycles without a tick
  p_time_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RUN && !tick && !flush) |=> (tim == $past(tim)));
  // R4: with a steady nonzero limit the elapsed time stays below it
  p_time_below_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lim != '0 && $stable(lim)) |-> (tim < lim));
endmodule

// File: rtl/event_pacer.sv
module event_pacer
  import pacer_pkg::*;
#(
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned TIME_LSB = 16,
  parameter int unsigned CNT_LSB  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              tick,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              evt_out,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [TIME_W-1:0] time_o
);
  pace_cfg_t cfg;
  logic div_en_eff, dly_en_eff;
  logic div_fire, dly_fire, flush;
  logic div_out, dly_out;

  pace_cfg_decode #(
    .CFG_W(CFG_W), .TIME_LSB(TIME_LSB), .CNT_LSB(CNT_LSB),
    .DIV_BIT(0), .DLY_BIT(1)
  ) u_dec (
    .cfg_word(cfg_word),
    .cfg     (cfg)
  );

  // A zero count limit forces pass-through; a zero time limit parks the delay path.
  assign div_en_eff = cfg.div_en || (cfg.cnt_lim == '0);
  assign dly_en_eff = cfg.dly_en && (cfg.time_lim != '0);

  // Either limit firing flushes both machines, giving one pulse.
  assign flush = div_fire || dly_fire;

  pace_divider #(.W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .evt(evt_in), .en(div_en_eff),
    .lim(cfg.cnt_lim), .flush(flush),
    .cnt(cnt_o), .fire(div_fire), .at_out(div_out)
  );

  pace_delay #(.W(TIME_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .evt(evt_in), .tick(tick), .en(dly_en_eff),
    .lim(cfg.time_lim), .flush(flush),
    .tim(time_o), .fire(dly_fire), .at_out(dly_out)
  );

  assign evt_out = div_out;

  // R7: both machines sit in their output state together
  p_joint_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_out ^ dly_out));
  // R7: status reads zero during the output cycle
  p_out_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> (cnt_o == '0 && time_o == '0));
  // R3/R4: an output always follows an event or a tick
  p_out_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> $past(evt_in || tick));
endmodule

// File: tb/event_pacer_bench.sv
module event_pacer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_in = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        evt_out;
  logic [7:0]  cnt_o;
  logic [11:0] time_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cnt = 0, m_tim = 0;
  bit m_run = 0, m_out = 0;
  int pass_in = 0, pass_out = 0;

  always #2 clk = ~clk;

  event_pacer u_event_pacer (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick(tick),
    .cfg_word(cfg_word), .evt_out(evt_out), .cnt_o(cnt_o), .time_o(time_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // model steps at each rising edge, compare one unit later
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_cnt = 0; m_tim = 0; m_run = 0; m_out = 0;
    end else begin
      int tl, cl;
      bit den, ten, pass, dfire, tfire;
      tl = cfg_word[27:16];
      cl = cfg_word[15:8];
      den = cfg_word[0];
      ten = cfg_word[1] && tl != 0;
      pass = evt_in && cl == 0;
      dfire = den && evt_in && (m_cnt + 1 >= cl);
      tfire = ten && m_run && tick && (m_tim + 1 >= tl);
      if (pass) pass_in++;
      if (pass || dfire || tfire) begin
        m_out = 1; m_cnt = 0; m_tim = 0; m_run = 0;
      end else begin
        m_out = 0;
        if (den && evt_in) m_cnt++;
        if (ten) begin
          if (!m_run && evt_in) begin m_run = 1; m_tim = 0; end
          else if (m_run && tick) m_tim++;
        end
      end
    end
    #1;
    if (evt_out === 1'b1) pass_out++;
    check(cur_req, "evt_out", int'(evt_out), int'(m_out));
    check(cur_req, "cnt_o", int'(cnt_o), m_cnt);
    check(cur_req, "time_o", int'(time_o), m_tim);
  end

  task automatic segment(input string req, input logic [31:0] cfg, input int n,
                         input int pe, input int pt);
    @(negedge clk);
    rst_n = 1'b0; evt_in = 1'b0; tick = 1'b0;
    cur_req = req;
    cfg_word = cfg;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pass_in = 0; pass_out = 0;
    for (int i = 0; i < n; i++) begin
      evt_in = ($urandom_range(99) < pe);
      tick   = ($urandom_range(99) < pt);
      @(negedge clk);
    end
    evt_in = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values seen at the ports
    check("R1", "evt_out in reset", int'(evt_out), 0);
    check("R1", "cnt_o in reset", int'(cnt_o), 0);
    check("R1", "time_o in reset", int'(time_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cnt_o after reset", int'(cnt_o), 0);

    // R3: divide only, limit 4
    segment("R3", {4'h0, 12'd0, 8'd4, 8'h01}, 400, 40, 0);
    // R4: delay only, limit 5 ticks
    segment("R4", {4'h0, 12'd5, 8'd0, 8'h02} | 32'h0000_0100 * 8'd200, 600, 10, 30);
    // R2/R7: both paths together
    segment("R2", {4'h0, 12'd4, 8'd3, 8'h03}, 600, 25, 35);
    segment("R7", {4'h0, 12'd2, 8'd6, 8'h03}, 600, 50, 60);
    // R5: zero time limit leaves only the count
    segment("R5", {4'h0, 12'd0, 8'd2, 8'h03}, 400, 40, 50);
    // R6: pass-through
    segment("R6", {4'h0, 12'd7, 8'd0, 8'h00}, 300, 50, 50);
    check("R6", "pulses out vs in", pass_out, pass_in);
    // R8: dense events, limit 1 and a long delay
    segment("R8", {4'h0, 12'd9, 8'd1, 8'h03}, 300, 90, 20);
    segment("R8", {4'h0, 12'd3, 8'd50, 8'h02}, 400, 80, 30);
    // R9: reserved bits set
    segment("R9", {4'hF, 12'd4, 8'd3, 8'hFF} & 32'hFFFF_FFFF, 500, 30, 40);
    // R10: both paths off
    segment("R10", {4'h0, 12'd5, 8'd3, 8'h00}, 300, 60, 60);
    check("R10", "outputs with paths off", pass_out, 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired (actual=timeout expected=finish)");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule